// File: doc/BRIEF.md
# PLL Output Frequency Calculator

This block works out the output frequency of a clock synthesiser from its divider settings and the reference frequency. After a start pulse it captures a feedback multiplier, a pre-divider, a post-divider exponent and, in fractional mode, a signed 16-bit fractional trim. It builds a wide numerator and a divisor from these inputs. A serial restoring divider then produces the quotient one bit per clock.

In integer mode the result is `fin * mul / (pre << post)`. In fractional mode the multiplier is extended by sixteen fraction bits, so the numerator is `fin * (mul * 65536 + frac)` and the divisor is `(pre * 65536) << post`. The post-divider always shifts the divisor and never the quotient, so the result is a single floor of the exact ratio. A zero pre-divider cannot be divided by: the block reports it right away with an error flag and a zero result. Clock-management logic or a monitoring path uses the block to report the frequency that a set of divider fields will give.

Top module: `pll_freq_calc`

## Requirements
- R1: With `frac_mode_i`=0, the result is floor(fin × mul / (pre << post)). `frac_i` has no effect in this mode.
- R2: With `frac_mode_i`=1, the result is floor(fin × (mul × 65536 + frac) / ((pre × 65536) << post)). For example, fin=24000000, mul=262, pre=2, post=3 and frac=9437 give 393215995.
- R3: `frac_i` is a 16-bit two's-complement value. Bit 15 set means a negative trim, which lowers the effective multiplier below mul × 65536.
- R4: If the effective multiplier (mul × 65536 + frac) is negative, the result is 0 and `err_o` stays low.
- R5: A start with `pre_i`=0 gives `done_o`, `err_o`=1 and `freq_o`=0 on the clock after the start is accepted. No division is run.
- R6: A start with `pre_i`≠0 gives `done_o` exactly NUM_W clocks after the edge that accepted the start. `err_o` is 0 on that cycle.
- R7: `done_o` is high for exactly one clock per accepted start.
- R8: `freq_o` and `err_o` change only on the cycle where `done_o` is high, and otherwise hold their values until the next result.
- R9: A start pulse that arrives while a division is in progress is ignored. It does not change the pending result, its timing, or the number of done pulses.
- R10: After reset, `freq_o`=0, `done_o`=0 and `err_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; the operands are sampled when it is accepted |
| frac_mode_i | input | 1 | 1 = fractional formula, 0 = integer formula |
| fin_i | input | 32 | Reference frequency |
| mul_i | input | 10 | Feedback multiplier |
| pre_i | input | 6 | Pre-divider |
| post_i | input | 3 | Post-divider exponent (shift of the divisor) |
| frac_i | input | 16 | Signed fractional trim |
| freq_o | output | 64 | Computed frequency, held between results |
| done_o | output | 1 | One-clock pulse when a result is valid |
| err_o | output | 1 | High with a result produced from a zero pre-divider |

## Verification
Two situations are hard to reach from the ports. The first is a start pulse that lands in the middle of a division. The bench raises start again several cycles after launching a job, with different operands. It then confirms that the first job's quotient and latency survive and that no second done pulse follows. The second is a negative effective multiplier. Random fields almost never give one, so the bench aims at it directly with mul of 0 or 1 and trims near the negative limit. It also places quotient bits near the top of the 64-bit numerator, using large references with the largest multiplier and the smallest divisors.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
   // Operating formula selected by the mode input
   typedef enum logic {
      PFC_INT  = 1'b0,
      PFC_FRAC = 1'b1
   } pfc_mode_e;

   // Divisor width: pre-divider, fraction scaling and the largest post shift
   function automatic int pfc_den_w(input int p_w, input int frac_sh, input int s_w);
      return p_w + frac_sh + (2 ** s_w) - 1;
   endfunction
endpackage

// File: rtl/pfc_operand.sv
module pfc_operand
   import pfc_pkg::*;
#(
   parameter int FIN_W   = 32,
   parameter int M_W     = 10,
   parameter int P_W     = 6,
   parameter int S_W     = 3,
   parameter int K_W     = 16,
   parameter int NUM_W   = 64,
   parameter bit FRAC_EN = 1'b1,
   localparam int DEN_W  = pfc_den_w(P_W, K_W, S_W)
) (
   input  logic             frac_mode_i,
   input  logic [FIN_W-1:0] fin_i,
   input  logic [M_W-1:0]   mul_i,
   input  logic [P_W-1:0]   pre_i,
   input  logic [S_W-1:0]   post_i,
   input  logic [K_W-1:0]   frac_i,
   output logic [NUM_W-1:0] num_o,
   output logic [DEN_W-1:0] den_o
);
   localparam int CW = M_W + K_W + 2;

   logic [NUM_W-1:0] fin_x;
   logic [DEN_W-1:0] pre_x;
   logic [NUM_W-1:0] num_int;
   logic [DEN_W-1:0] den_int;

   assign fin_x   = {{(NUM_W-FIN_W){1'b0}}, fin_i};
   assign pre_x   = {{(DEN_W-P_W){1'b0}}, pre_i};
   assign num_int = fin_x * {{(NUM_W-M_W){1'b0}}, mul_i};
   assign den_int = pre_x << post_i;

   generate
      if (FRAC_EN) begin : g_frac
         logic signed [CW-1:0] coef;
         logic [NUM_W-1:0]     num_frac;
         logic [DEN_W-1:0]     den_frac;

         always_comb begin
            coef = $signed({2'b00, mul_i, {K_W{1'b0}}})
                 + $signed({{(CW-K_W){frac_i[K_W-1]}}, frac_i});
         end

         // A negative effective multiplier is clamped to a zero numerator
         assign num_frac = coef[CW-1] ? '0
                         : fin_x * {{(NUM_W-CW+1){1'b0}}, coef[CW-2:0]};
         assign den_frac = pre_x << (K_W + int'(post_i));

         assign num_o = (pfc_mode_e'(frac_mode_i) == PFC_FRAC) ? num_frac : num_int;
         assign den_o = (pfc_mode_e'(frac_mode_i) == PFC_FRAC) ? den_frac : den_int;
      end else begin : g_int_only
         assign num_o = num_int;
         assign den_o = den_int;
      end
   endgenerate
endmodule

// File: rtl/pfc_divider.sv
module pfc_divider #(
   parameter int NUM_W = 64,
   parameter int DEN_W = 29
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             step_i,
   input  logic [NUM_W-1:0] dividend_i,
   input  logic [DEN_W-1:0] divisor_i,
   output logic [NUM_W-1:0] quot_nxt_o
);
   logic [NUM_W-1:0] q_q;
   logic [DEN_W-1:0] r_q;
   logic [DEN_W-1:0] d_q;
   logic [DEN_W:0]   sh;
   logic             ge;
   logic [DEN_W-1:0] diff;
   logic [DEN_W-1:0] r_nxt;

   always_comb begin
      sh    = {r_q, q_q[NUM_W-1]};
      ge    = sh >= {1'b0, d_q};
      diff  = sh[DEN_W-1:0] - d_q;
      r_nxt = ge ? diff : sh[DEN_W-1:0];
   end

   assign quot_nxt_o = {q_q[NUM_W-2:0], ge};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_q <= '0;
         r_q <= '0;
         d_q <= '0;
      end else if (load_i) begin
         q_q <= dividend_i;
         r_q <= '0;
         d_q <= divisor_i;
      end else if (step_i) begin
         q_q <= quot_nxt_o;
         r_q <= r_nxt;
      end
   end
endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc
   import pfc_pkg::*;
#(
   parameter int FIN_W   = 32,
   parameter int M_W     = 10,
   parameter int P_W     = 6,
   parameter int S_W     = 3,
   parameter int K_W     = 16,
   parameter int NUM_W   = 64,
   parameter bit FRAC_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             frac_mode_i,
   input  logic [FIN_W-1:0] fin_i,
   input  logic [M_W-1:0]   mul_i,
   input  logic [P_W-1:0]   pre_i,
   input  logic [S_W-1:0]   post_i,
   input  logic [K_W-1:0]   frac_i,
   output logic [NUM_W-1:0] freq_o,
   output logic             done_o,
   output logic             err_o
);
   localparam int DEN_W = pfc_den_w(P_W, K_W, S_W);
   localparam int CNT_W = $clog2(NUM_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_W - 1);

   generate
      if (NUM_W < FIN_W + M_W + K_W + 1) begin : g_bad_num_w
         $error("pll_freq_calc: NUM_W too small for the numerator");
      end
      if (P_W < 1 || S_W < 1 || M_W < 1) begin : g_bad_field_w
         $error("pll_freq_calc: field widths must be at least one bit");
      end
      if (NUM_W < 2) begin : g_bad_div_w
         $error("pll_freq_calc: NUM_W must be at least 2");
      end
   endgenerate

   logic [NUM_W-1:0] num;
   logic [DEN_W-1:0] den;
   logic [NUM_W-1:0] quot_nxt;
   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;
   logic [NUM_W-1:0] freq_q;
   logic             done_q;
   logic             err_q;
   logic             accept;
   logic             pre_zero;

   assign accept   = start_i && !busy_q;
   assign pre_zero = (pre_i == '0);

   pfc_operand #(
      .FIN_W  (FIN_W),
      .M_W    (M_W),
      .P_W    (P_W),
      .S_W    (S_W),
      .K_W    (K_W),
      .NUM_W  (NUM_W),
      .FRAC_EN(FRAC_EN)
   ) u_operand (
      .frac_mode_i(frac_mode_i),
      .fin_i      (fin_i),
      .mul_i      (mul_i),
      .pre_i      (pre_i),
      .post_i     (post_i),
      .frac_i     (frac_i),
      .num_o      (num),
      .den_o      (den)
   );

   pfc_divider #(
      .NUM_W(NUM_W),
      .DEN_W(DEN_W)
   ) u_divider (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (accept && !pre_zero),
      .step_i    (busy_q),
      .dividend_i(num),
      .divisor_i (den),
      .quot_nxt_o(quot_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         freq_q <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (busy_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               freq_q <= quot_nxt;
               err_q  <= 1'b0;
            end
         end else if (accept) begin
            if (pre_zero) begin
               done_q <= 1'b1;
               err_q  <= 1'b1;
               freq_q <= '0;
            end else begin
               busy_q <= 1'b1;
               cnt_q  <= '0;
            end
         end
      end
   end

   assign freq_o = freq_q;
   assign done_o = done_q;
   assign err_o  = err_q;
endmodule

// File: rtl/pfc_check.sv
module pfc_check #(
   parameter int NUM_W = 64,
   parameter int P_W   = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [P_W-1:0]   pre_i,
   input logic             busy_i,
   input logic [NUM_W-1:0] freq_o,
   input logic             done_o,
   input logic             err_o
);
   localparam int CW = $clog2(NUM_W + 3);
   localparam logic [CW-1:0] TOP = {CW{1'b1}};

   logic [CW-1:0] cyc_q;

   // Cycles since the last accepted start, saturating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cyc_q <= '0;
      else if (start_i && !busy_i) cyc_q <= CW'(1);
      else if (cyc_q != '0 && cyc_q != TOP) cyc_q <= cyc_q + 1'b1;
   end

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(freq_o) && $stable(err_o)));

   p_err_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (freq_o == '0));

   p_pre_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_i && pre_i == '0) |=> (done_o && err_o));

   p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o) |-> (cyc_q == CW'(NUM_W + 1)));
endmodule

bind pll_freq_calc pfc_check #(
   .NUM_W(NUM_W),
   .P_W  (P_W)
) u_pfc_check (
   .clk    (clk),
   .rst_n  (rst_n),
   .start_i(start_i),
   .pre_i  (pre_i),
   .busy_i (busy_q),
   .freq_o (freq_o),
   .done_o (done_o),
   .err_o  (err_o)
);

// File: tb/tb_pll_freq_calc.sv
module tb_pll_freq_calc;
   localparam int NUM_W = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        frac_mode_i = 1'b0;
   logic [31:0] fin_i = '0;
   logic [9:0]  mul_i = '0;
   logic [5:0]  pre_i = '0;
   logic [2:0]  post_i = '0;
   logic [15:0] frac_i = '0;
   logic [63:0] freq_o;
   logic        done_o;
   logic        err_o;

   int errors = 0;
   int checks = 0;
   int unsigned lcg = 32'h1234_5678;

   always #10 clk = ~clk;

   pll_freq_calc dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .frac_mode_i(frac_mode_i),
      .fin_i(fin_i), .mul_i(mul_i), .pre_i(pre_i), .post_i(post_i),
      .frac_i(frac_i), .freq_o(freq_o), .done_o(done_o), .err_o(err_o)
   );

   function automatic longint unsigned model(bit fm, int unsigned fin, int m,
                                             int p, int s, int k);
      longint signed coef;
      longint unsigned num, den;
      int ks;
      if (p == 0) return 64'd0;
      ks   = (k >= 32768) ? k - 65536 : k;
      coef = fm ? (longint'(m) * 65536 + ks) : longint'(m);
      if (coef < 0) coef = 0;
      num  = longint'(fin) * coef;
      den  = fm ? ((longint'(p) * 65536) << s) : (longint'(p) << s);
      return num / den;
   endfunction

   task automatic chk(bit ok, string tag, longint unsigned act, longint unsigned exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic drive(bit fm, int unsigned fin, int m, int p, int s, int k);
      frac_mode_i = fm;
      fin_i  = fin;
      mul_i  = 10'(m);
      pre_i  = 6'(p);
      post_i = 3'(s);
      frac_i = 16'(k);
   endtask

   // Launch one job and count negedges until done; n=0 means no done seen
   task automatic launch_wait(bit fm, int unsigned fin, int m, int p, int s, int k,
                              output int n);
      @(negedge clk);
      drive(fm, fin, m, p, s, k);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      n = 0;
      for (int i = 1; i <= NUM_W + 10; i++) begin
         if (done_o) begin n = i; break; end
         @(negedge clk);
      end
   endtask

   // Full job with result, latency, pulse width and hold checks
   task automatic run(bit fm, int unsigned fin, int m, int p, int s, int k, string tag);
      int n;
      longint unsigned exp, got;
      exp = model(fm, fin, m, p, s, k);
      launch_wait(fm, fin, m, p, s, k, n);
      got = freq_o;
      if (p == 0) begin
         chk(n == 1, "R5 latency", n, 1);
         chk(err_o == 1'b1, "R5 err", err_o, 1);
      end else begin
         chk(n == NUM_W + 1, "R6 latency", n, NUM_W + 1);
         chk(err_o == 1'b0, "R6 err", err_o, 0);
      end
      chk(got == exp, tag, got, exp);
      @(negedge clk);
      chk(done_o == 1'b0, "R7 pulse", done_o, 0);
      drive(~fm, 32'hDEAD_BEEF, 1023, 63, 7, 16'h8000);
      repeat (3) @(negedge clk);
      chk(freq_o == got, "R8 hold", freq_o, got);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int n;
      longint unsigned exp_a;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(freq_o == 0, "R10 freq", freq_o, 0);
      chk(done_o == 0, "R10 done", done_o, 0);
      chk(err_o == 0, "R10 err", err_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 worked example
      run(1'b1, 24_000_000, 262, 2, 3, 9437, "R2 example");
      chk(freq_o == 64'd393215995, "R2 example literal", freq_o, 64'd393215995);
      // R1 integer mode, frac_i ignored
      run(1'b0, 24_000_000, 250, 3, 1, 0, "R1 int");
      run(1'b0, 24_000_000, 250, 3, 1, 16'h7FFF, "R1 frac ignored");
      // R3 negative trim lowers the result
      run(1'b1, 24_000_000, 173, 2, 1, 16'hC000, "R3 negative k");
      run(1'b1, 24_000_000, 173, 2, 1, 16'h4000, "R3 positive k");
      // R4 negative effective multiplier
      run(1'b1, 24_000_000, 0, 1, 0, 16'hFFFF, "R4 clamp m0");
      run(1'b1, 100_000, 0, 5, 2, 16'h8000, "R4 clamp min");
      run(1'b1, 24_000_000, 1, 1, 0, 16'h8000, "R4 border m1");
      // R5 zero pre-divider, then recovery
      run(1'b1, 24_000_000, 300, 0, 2, 5, "R5 zero pre");
      run(1'b0, 24_000_000, 300, 0, 0, 0, "R5 zero pre int");
      run(1'b0, 19_200_000, 300, 1, 0, 0, "R5 recover");
      // Large quotient bits
      run(1'b0, 32'hFFFF_FFFF, 1023, 1, 0, 0, "R1 max");
      run(1'b1, 32'hFFFF_FFFF, 1023, 1, 0, 16'h7FFF, "R2 max");

      // Sweep of pre-divider, post shift and both modes
      for (int p = 0; p < 64; p++) begin
         for (int fm = 0; fm < 2; fm++) begin
            int unsigned fin;
            int m, k;
            lcg = lcg * 1664525 + 1013904223;
            fin = lcg;
            lcg = lcg * 1664525 + 1013904223;
            m = int'(lcg[25:16]);
            k = int'(lcg[15:0]);
            run(fm[0], fin, m, p, (p + fm) % 8, k, fm ? "R2 sweep" : "R1 sweep");
         end
      end

      // R9 start while busy is ignored
      exp_a = model(1'b1, 27_000_000, 361, 3, 3, 17511);
      @(negedge clk);
      drive(1'b1, 27_000_000, 361, 3, 3, 17511);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      n = 1;
      repeat (9) begin @(negedge clk); n++; end
      drive(1'b0, 1000, 7, 0, 0, 0);
      start_i = 1'b1;
      @(negedge clk);
      n++;
      start_i = 1'b0;
      while (!done_o && n < NUM_W + 10) begin @(negedge clk); n++; end
      chk(n == NUM_W + 1, "R9 latency kept", n, NUM_W + 1);
      chk(freq_o == exp_a, "R9 result kept", freq_o, exp_a);
      chk(err_o == 1'b0, "R9 err kept", err_o, 0);
      n = 0;
      repeat (NUM_W + 5) begin @(negedge clk); if (done_o) n++; end
      chk(n == 0, "R9 no extra done", n, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule